// File: doc/BRIEF.md
# Pixel Configuration Shift-and-Hold Register

This block stores the per-pixel settings of a pixel matrix. The settings arrive one bit at a time on a serial daisy chain. The block has an 11-stage shift chain that advances on each clock edge where the shift enable is high. The serial output of one pixel feeds the serial input of the next, so a single stream can configure a whole column.

A separate load strobe copies the shift chain into a holding register in one edge. Only the holding register drives the pixel. While a new stream moves through the chain, the active trim codes and test mode therefore stay unchanged.

The held word has three fields:
- a 4-bit trim code for the lower-threshold DAC;
- a 4-bit trim code for the upper-threshold DAC;
- a 3-bit test-mode code.

A decoder expands the test-mode code into individual enables for the pixel's analog switches. The daisy chain has no back-pressure: shift enable and load are plain control pins, and each enabled edge consumes one bit.

Top module: `pcfg_reg`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the shift chain and the holding register clear to zero. The pixel is then in normal mode with both trim codes at 0, `ser_out` is 0, `mode_normal` is 1 and `cnt_en` is 1.
- R2: On an edge with `shift_en` high, `ser_in` enters the first stage and every stage takes the value of the stage before it. `ser_out` is the last stage, so it shows the bit that was shifted in 11 shifts earlier. On an edge with `shift_en` low, the chain holds its contents.
- R3: Field order is fixed. The 11 bits are shifted in this order: `trim_lo[3]` down to `trim_lo[0]`, then `trim_hi[3]` down to `trim_hi[0]`, then `mode_code[2]` down to `mode_code[0]`. After these 11 shifts and a load, the outputs show exactly those fields.
- R4: The held outputs (`trim_lo`, `trim_hi`, `mode_code` and all decoded enables) change only on an edge where `load` is high. Shifting without a load leaves them unchanged.
- R5: When `load` and `shift_en` are high on the same edge, the holding register takes the chain contents as they were before that edge's shift.
- R6: Mode code 3'b000 (normal) sets `mode_normal` and `cnt_en` high and all other enables low.
- R7: Mode code 3'b001 (analog monitor) sets only `ana_mon_en` high. `cnt_en` is low.
- R8: Mode code 3'b010 (test injection) sets `test_inj_en` and `cnt_en` high and all others low.
- R9: Mode code 3'b011 sets only `cal_lo_en` high, and code 3'b100 sets only `cal_hi_en` high. `cnt_en` is low for both.
- R10: Mode code 3'b111 sets only `pix_off` high. `cnt_en` and every other enable are low.
- R11: The unused codes 3'b101 and 3'b110 decode exactly as normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_en | input | 1 | Advance the shift chain by one bit |
| ser_in | input | 1 | Serial data from the previous pixel |
| load | input | 1 | Copy the chain into the holding register |
| ser_out | output | 1 | Last chain stage, to the next pixel |
| trim_lo | output | 4 | Held lower-threshold DAC trim code |
| trim_hi | output | 4 | Held upper-threshold DAC trim code |
| mode_code | output | 3 | Held test-mode code |
| mode_normal | output | 1 | Normal operation |
| ana_mon_en | output | 1 | Analog output routed for monitoring |
| test_inj_en | output | 1 | Test charge input enabled |
| cal_lo_en | output | 1 | Lower DAC calibration |
| cal_hi_en | output | 1 | Upper DAC calibration |
| pix_off | output | 1 | Pixel disabled |
| cnt_en | output | 1 | Counter connected to the discriminator |

## Verification
The bench streams every one of the 2048 possible words into the chain, most significant field first, and then loads each one.

Three observations separate faults:
- Comparing each loaded field with the streamed word catches swapped or reversed fields.
- Checking the outputs after the shifts but before the load catches outputs that leak through without a load.
- The bits that leave on `ser_out` while the next word enters must replay the previous word in order, which exposes a wrong stage or chain length.

Because the sweep covers all 2048 words, every mode code is decoded under all 256 trim-code combinations. Two directed cases cover idle edges with `ser_in` toggling and a load on the same edge as a shift.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_NORMAL  = 3'b000,
    MODE_MON     = 3'b001,
    MODE_INJ     = 3'b010,
    MODE_CAL_LO  = 3'b011,
    MODE_CAL_HI  = 3'b100,
    MODE_SPARE_A = 3'b101,
    MODE_SPARE_B = 3'b110,
    MODE_OFF     = 3'b111
  } mode_e;

  typedef struct packed {
    logic normal;
    logic mon;
    logic inj;
    logic cal_lo;
    logic cal_hi;
    logic off;
    logic cnt;
  } ctrl_t;

endpackage

// File: rtl/pcfg_shift_chain.sv
module pcfg_shift_chain #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         ser_in,
  output logic [W-1:0] stages
);

  always_ff @(posedge clk) begin
    if (!rst_n)        stages[0] <= 1'b0;
    else if (shift_en) stages[0] <= ser_in;
  end

  for (genvar i = 1; i < W; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)        stages[i] <= 1'b0;
      else if (shift_en) stages[i] <= stages[i-1];
    end
  end

  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> stages[0] == $past(ser_in)); // R2
  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> stages[W-1:1] == $past(stages[W-2:0])); // R2
  AST_CHAIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(stages)); // R2

endmodule

// File: rtl/pcfg_hold.sv
module pcfg_hold #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q)); // R4
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q == $past(d)); // R5

endmodule

// File: rtl/pcfg_mode_decode.sv
module pcfg_mode_decode
  import pcfg_pkg::*;
(
  input  logic [MODE_W-1:0] code,
  output ctrl_t             ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (mode_e'(code))
      MODE_MON:    ctrl.mon    = 1'b1;
      MODE_INJ:    begin ctrl.inj = 1'b1; ctrl.cnt = 1'b1; end
      MODE_CAL_LO: ctrl.cal_lo = 1'b1;
      MODE_CAL_HI: ctrl.cal_hi = 1'b1;
      MODE_OFF:    ctrl.off    = 1'b1;
      MODE_NORMAL, MODE_SPARE_A, MODE_SPARE_B: begin
        ctrl.normal = 1'b1;
        ctrl.cnt    = 1'b1;
      end
      default:     ctrl = '0;
    endcase
  end

endmodule

// File: rtl/pcfg_reg.sv
module pcfg_reg
  import pcfg_pkg::*;
#(
  parameter int TRIM_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              ser_in,
  input  logic              load,
  output logic              ser_out,
  output logic [TRIM_W-1:0] trim_lo,
  output logic [TRIM_W-1:0] trim_hi,
  output logic [MODE_W-1:0] mode_code,
  output logic              mode_normal,
  output logic              ana_mon_en,
  output logic              test_inj_en,
  output logic              cal_lo_en,
  output logic              cal_hi_en,
  output logic              pix_off,
  output logic              cnt_en
);

  localparam int CHAIN_W = 2 * TRIM_W + MODE_W;
  localparam int LO_MSB  = CHAIN_W - 1;
  localparam int HI_MSB  = MODE_W + TRIM_W - 1;

  logic [CHAIN_W-1:0] chain;
  logic [CHAIN_W-1:0] held;
  ctrl_t              ctrl;

  pcfg_shift_chain #(.W(CHAIN_W)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .ser_in   (ser_in),
    .stages   (chain)
  );

  pcfg_hold #(.W(CHAIN_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .d     (chain),
    .q     (held)
  );

  assign ser_out   = chain[CHAIN_W-1];
  assign trim_lo   = held[LO_MSB -: TRIM_W];
  assign trim_hi   = held[HI_MSB -: TRIM_W];
  assign mode_code = held[MODE_W-1:0];

  pcfg_mode_decode u_dec (
    .code (mode_code),
    .ctrl (ctrl)
  );

  assign mode_normal = ctrl.normal;
  assign ana_mon_en  = ctrl.mon;
  assign test_inj_en = ctrl.inj;
  assign cal_lo_en   = ctrl.cal_lo;
  assign cal_hi_en   = ctrl.cal_hi;
  assign pix_off     = ctrl.off;
  assign cnt_en      = ctrl.cnt;

  AST_OFF_ISOLATES: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'b111) |-> (!cnt_en && !ana_mon_en && !test_inj_en)); // R10
  AST_SPARE_AS_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'b101 || mode_code == 3'b110) |-> (mode_normal && cnt_en)); // R11
  AST_CAL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cal_lo_en, cal_hi_en}) <= 1); // R9
  AST_ENABLES_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mode_normal, ana_mon_en, test_inj_en, cal_lo_en, cal_hi_en, pix_off})); // R6
  AST_MON_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ana_mon_en |-> !cnt_en); // R7

endmodule

// File: tb/pcfg_reg_tb.sv
module pcfg_reg_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_en = 1'b0;
  logic ser_in = 1'b0;
  logic load = 1'b0;
  logic ser_out, mode_normal, ana_mon_en, test_inj_en, cal_lo_en, cal_hi_en, pix_off, cnt_en;
  logic [3:0] trim_lo, trim_hi;
  logic [2:0] mode_code;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pcfg_reg u_dut (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .ser_in(ser_in), .load(load),
    .ser_out(ser_out), .trim_lo(trim_lo), .trim_hi(trim_hi), .mode_code(mode_code),
    .mode_normal(mode_normal), .ana_mon_en(ana_mon_en), .test_inj_en(test_inj_en),
    .cal_lo_en(cal_lo_en), .cal_hi_en(cal_hi_en), .pix_off(pix_off), .cnt_en(cnt_en)
  );

  // Expected enables {normal, mon, inj, cal_lo, cal_hi, off, cnt}
  function automatic logic [6:0] exp_dec(input logic [2:0] c);
    case (c)
      3'b001:  return 7'b0100000;
      3'b010:  return 7'b0010001;
      3'b011:  return 7'b0001000;
      3'b100:  return 7'b0000100;
      3'b111:  return 7'b0000010;
      default: return 7'b1000001;
    endcase
  endfunction

  function automatic string dec_tag(input logic [2:0] c);
    case (c)
      3'b000:  return "R6";
      3'b001:  return "R7";
      3'b010:  return "R8";
      3'b011, 3'b100: return "R9";
      3'b111:  return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] held_word();
    return {trim_lo, trim_hi, mode_code};
  endfunction

  function automatic logic [6:0] enables();
    return {mode_normal, ana_mon_en, test_inj_en, cal_lo_en, cal_hi_en, pix_off, cnt_en};
  endfunction

  task automatic shift_word(input logic [10:0] w, input logic [10:0] prev);
    for (int k = 0; k < 11; k++) begin
      @(negedge clk);
      chk("R2 ser_out replay", ser_out, prev[10-k]);
      ser_in = w[10-k];
      shift_en = 1'b1;
    end
    @(negedge clk);
    shift_en = 1'b0;
  endtask

  task automatic do_load();
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  initial begin
    logic [10:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 held word", held_word(), 11'h0);
    chk("R1 ser_out", ser_out, 1'b0);
    chk("R1 enables", enables(), 7'b1000001);

    prev = '0;
    for (int w = 0; w < 2048; w++) begin
      logic [10:0] word;
      word = 11'(w);
      shift_word(word, prev);
      chk("R4 held before load", held_word(), prev);
      chk("R4 enables before load", enables(), exp_dec(prev[2:0]));
      do_load();
      chk("R3 trim_lo", trim_lo, word[10:7]);
      chk("R3 trim_hi", trim_hi, word[6:3]);
      chk("R3 mode_code", mode_code, word[2:0]);
      chk(dec_tag(word[2:0]), enables(), exp_dec(word[2:0]));
      prev = word;
    end

    // R2: idle edges with toggling ser_in leave the chain unchanged
    shift_word(11'h5A3, prev);
    for (int k = 0; k < 4; k++) begin
      ser_in = k[0];
      @(negedge clk);
    end
    do_load();
    chk("R2 chain held while idle", held_word(), 11'h5A3);

    // R5: load on the same edge as a shift captures pre-shift contents
    ser_in = 1'b1;
    shift_en = 1'b1;
    load = 1'b1;
    @(negedge clk);
    shift_en = 1'b0;
    load = 1'b0;
    chk("R5 load with shift", held_word(), 11'h5A3);
    do_load();
    chk("R5 shifted word later", held_word(), 11'h347);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule